// File: doc/BRIEF.md
# Thread Block Barrier Unit

This unit coordinates a barrier for the threads of one thread block. When a thread reaches the barrier it signals an arrival that carries its thread index. The unit then marks that thread as waiting, and the scheduler treats a waiting thread as not eligible to run. The unit also counts the arrivals. When the count equals the block size configured for the current launch, the unit releases the whole block in a single event. In that one cycle it pulses a release output, clears every waiting flag and sets the counter back to zero. The next barrier can therefore begin on the following cycle.

The block size is captured by a launch strobe and can be any value from 1 to the thread limit. The default limit is 512. A launch with an impossible size is refused. Several arrival ports are sampled in every cycle, and all valid arrivals in a cycle are counted in that same cycle. Two kinds of bad arrival are not counted and set a sticky error flag:
- a repeated arrival from a thread that is already waiting;
- an arrival for a thread outside the configured block.

Top module: `barrier_sync_unit`

## Requirements
- R1: After synchronous reset the following hold: no thread is waiting, the arrival count is 0, release is low, no block is active, and both error flags are clear.
- R2: A launch with a size from 1 to THREADS latches that size, makes the block active, and clears the count and all waiting flags on the next cycle.
- R3: A launch with size 0, or with a size above THREADS, is refused. The unit becomes inactive and the size error flag is set. The size error flag stays set until reset, even after a later valid launch.
- R4: An accepted arrival with thread index t sets waiting bit t and raises the count by one, both visible one cycle after the arrival.
- R5: Valid arrivals for distinct threads on several ports in the same cycle are all counted in that cycle.
- R6: When an accepted arrival brings the count to the block size, release is high for exactly the next cycle. In that same cycle all waiting bits are 0 and the count is 0.
- R7: An arrival presented during the release cycle is counted toward the next barrier.
- R8: An arrival from a thread that is already waiting is not counted and sets the sticky arrival error flag. So is a second port carrying the same index in the same cycle.
- R9: An arrival whose index is at or above the block size is not counted and sets the arrival error flag. An arrival while no block is active is treated the same way.
- R10: Arrivals in a launch cycle are ignored without error, and a launch discards any barrier in progress.
- R11: The number of set waiting bits always equals the count, and the count of an active block stays below its size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| launch_i | input | 1 | Block launch strobe |
| launch_size_i | input | CNT_W (10) | Thread count of the launched block |
| arr_valid_i | input | PORTS (4) | Arrival strobe per port |
| arr_tid_i | input | PORTS*TID_W (36) | Thread index per port, port p at bits p*TID_W upward |
| release_o | output | 1 | One-cycle barrier release pulse |
| waiting_o | output | THREADS (512) | Per-thread waiting flag, bit t for thread t |
| arrived_cnt_o | output | CNT_W (10) | Arrivals counted in the current barrier |
| active_o | output | 1 | A validly sized block is loaded |
| size_err_o | output | 1 | Sticky: a launch size was refused |
| arr_err_o | output | 1 | Sticky: an arrival was rejected |

## Verification
Any internal fault has one of two effects:
- a thread that stays waiting forever;
- a release that comes too early.

Both show at the ports within one cycle of the arrival that triggers them. A miscounted arrival shifts the release by at least one arrival, so the bench checks release at the exact cycle the block is complete and also one arrival before it. A waiting flag that fails to set or fails to clear breaks the rule that the number of set flags equals the count, and that mismatch is visible on the next cycle.

// File: rtl/bsync_pkg.sv
package bsync_pkg;

    localparam int unsigned MAX_THREADS = 512;
    localparam int unsigned ARR_PORTS   = 4;

    typedef enum logic [0:0] {
        BLK_IDLE   = 1'b0,
        BLK_ACTIVE = 1'b1
    } blk_state_e;

    typedef struct packed {
        logic size_bad;
        logic arrival_bad;
    } err_flags_t;

    function automatic int unsigned tid_width(input int unsigned threads);
        return (threads > 1) ? $clog2(threads) : 1;
    endfunction

    function automatic int unsigned cnt_width(input int unsigned threads);
        return $clog2(threads + 1);
    endfunction

endpackage

// File: rtl/bsync_arrival_filter.sv
module bsync_arrival_filter
    import bsync_pkg::*;
#(
    parameter int unsigned THREADS = MAX_THREADS,
    parameter int unsigned PORTS   = ARR_PORTS,
    localparam int unsigned TID_W  = tid_width(THREADS),
    localparam int unsigned CNT_W  = cnt_width(THREADS)
) (
    input  logic [PORTS-1:0]       arr_valid,
    input  logic [PORTS*TID_W-1:0] arr_tid,
    input  logic [THREADS-1:0]     waiting,
    input  logic [CNT_W-1:0]       blk_size,
    input  logic                   eligible,
    input  logic                   launch,
    output logic [PORTS-1:0]       accept,
    output logic [PORTS-1:0]       reject
);

    for (genvar p = 0; p < PORTS; p++) begin : g_port
        logic [TID_W-1:0] tid;
        logic             in_block;
        logic             seen_before;
        logic             already;

        assign tid      = arr_tid[p*TID_W +: TID_W];
        assign in_block = (CNT_W'(tid) < blk_size);
        assign already  = waiting[tid];

        always_comb begin
            seen_before = 1'b0;
            for (int q = 0; q < p; q++) begin
                if (arr_valid[q] && (arr_tid[q*TID_W +: TID_W] == tid))
                    seen_before = 1'b1;
            end
        end

        assign accept[p] = eligible && arr_valid[p] && in_block
                           && !already && !seen_before;
        assign reject[p] = arr_valid[p] && !launch && !accept[p];
    end

endmodule

// File: rtl/bsync_flag_array.sv
module bsync_flag_array
    import bsync_pkg::*;
#(
    parameter int unsigned THREADS = MAX_THREADS,
    parameter int unsigned PORTS   = ARR_PORTS,
    localparam int unsigned TID_W  = tid_width(THREADS)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [PORTS-1:0]       accept,
    input  logic [PORTS*TID_W-1:0] arr_tid,
    input  logic                   clear,
    output logic [THREADS-1:0]     waiting_q
);

    logic [THREADS-1:0] set_vec;

    for (genvar t = 0; t < THREADS; t++) begin : g_thread
        always_comb begin
            set_vec[t] = 1'b0;
            for (int p = 0; p < PORTS; p++) begin
                if (accept[p] && (arr_tid[p*TID_W +: TID_W] == TID_W'(t)))
                    set_vec[t] = 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (rst || clear)
                waiting_q[t] <= 1'b0;
            else if (set_vec[t])
                waiting_q[t] <= 1'b1;
        end
    end

    // R6: a release or launch empties the whole flag vector on the next cycle
    p_clear_empties_r6: assert property (@(posedge clk) disable iff (rst)
        clear |=> (waiting_q == '0));

endmodule

// File: rtl/bsync_count_ctrl.sv
module bsync_count_ctrl
    import bsync_pkg::*;
#(
    parameter int unsigned THREADS = MAX_THREADS,
    parameter int unsigned PORTS   = ARR_PORTS,
    localparam int unsigned CNT_W  = cnt_width(THREADS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             launch,
    input  logic [CNT_W-1:0] launch_size,
    input  logic [PORTS-1:0] accept,
    input  logic [PORTS-1:0] reject,
    output logic             eligible,
    output logic [CNT_W-1:0] blk_size_q,
    output logic [CNT_W-1:0] count_q,
    output logic             release_q,
    output logic             clear_flags,
    output logic             active,
    output err_flags_t       err_q
);

    blk_state_e       state_q;
    logic [CNT_W-1:0] n_new;
    logic [CNT_W:0]   sum;
    logic             size_ok;
    logic             fire;

    assign size_ok  = (launch_size != '0) && (launch_size <= CNT_W'(THREADS));
    assign eligible = (state_q == BLK_ACTIVE) && !launch;
    assign active   = (state_q == BLK_ACTIVE);

    always_comb begin
        n_new = '0;
        for (int p = 0; p < PORTS; p++)
            n_new = n_new + CNT_W'(accept[p]);
    end

    assign sum         = {1'b0, count_q} + {1'b0, n_new};
    assign fire        = eligible && (n_new != '0) && (sum == {1'b0, blk_size_q});
    assign clear_flags = launch || fire;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= BLK_IDLE;
            blk_size_q <= '0;
            count_q    <= '0;
            release_q  <= 1'b0;
            err_q      <= '0;
        end else begin
            release_q <= fire;
            if (|reject)
                err_q.arrival_bad <= 1'b1;
            if (launch) begin
                count_q <= '0;
                if (size_ok) begin
                    state_q    <= BLK_ACTIVE;
                    blk_size_q <= launch_size;
                end else begin
                    state_q        <= BLK_IDLE;
                    err_q.size_bad <= 1'b1;
                end
            end else if (eligible && (n_new != '0)) begin
                count_q <= fire ? '0 : sum[CNT_W-1:0];
            end
        end
    end

    // R3: refused launch leaves the block idle and flags the error
    p_bad_launch_r3: assert property (@(posedge clk) disable iff (rst)
        (launch && !size_ok) |=> (err_q.size_bad && !active));

    // R11: an active block never holds a count equal to its size
    p_count_below_size_r11: assert property (@(posedge clk) disable iff (rst)
        active |-> (count_q < blk_size_q));

    // R8: arrival error is sticky
    p_arr_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        err_q.arrival_bad |=> err_q.arrival_bad);

    // R3: size error is sticky
    p_size_err_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        err_q.size_bad |=> err_q.size_bad);

endmodule

// File: rtl/barrier_sync_unit.sv
module barrier_sync_unit
    import bsync_pkg::*;
#(
    parameter int unsigned THREADS = MAX_THREADS,
    parameter int unsigned PORTS   = ARR_PORTS,
    localparam int unsigned TID_W  = tid_width(THREADS),
    localparam int unsigned CNT_W  = cnt_width(THREADS)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   launch_i,
    input  logic [CNT_W-1:0]       launch_size_i,
    input  logic [PORTS-1:0]       arr_valid_i,
    input  logic [PORTS*TID_W-1:0] arr_tid_i,
    output logic                   release_o,
    output logic [THREADS-1:0]     waiting_o,
    output logic [CNT_W-1:0]       arrived_cnt_o,
    output logic                   active_o,
    output logic                   size_err_o,
    output logic                   arr_err_o
);

    logic [PORTS-1:0] accept;
    logic [PORTS-1:0] reject;
    logic             eligible;
    logic             clear_flags;
    logic [CNT_W-1:0] blk_size;
    err_flags_t       errs;

    bsync_arrival_filter #(.THREADS(THREADS), .PORTS(PORTS)) u_filter (
        .arr_valid (arr_valid_i),
        .arr_tid   (arr_tid_i),
        .waiting   (waiting_o),
        .blk_size  (blk_size),
        .eligible  (eligible),
        .launch    (launch_i),
        .accept    (accept),
        .reject    (reject)
    );

    bsync_flag_array #(.THREADS(THREADS), .PORTS(PORTS)) u_flags (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .arr_tid   (arr_tid_i),
        .clear     (clear_flags),
        .waiting_q (waiting_o)
    );

    bsync_count_ctrl #(.THREADS(THREADS), .PORTS(PORTS)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .launch      (launch_i),
        .launch_size (launch_size_i),
        .accept      (accept),
        .reject      (reject),
        .eligible    (eligible),
        .blk_size_q  (blk_size),
        .count_q     (arrived_cnt_o),
        .release_q   (release_o),
        .clear_flags (clear_flags),
        .active      (active_o),
        .err_q       (errs)
    );

    assign size_err_o = errs.size_bad;
    assign arr_err_o  = errs.arrival_bad;

    // R11: flag population and counter agree at all times
    p_flags_match_count_r11: assert property (@(posedge clk) disable iff (rst)
        ($countones(waiting_o) == int'(arrived_cnt_o)));

    // R6: the release cycle shows an empty barrier
    p_release_empty_r6: assert property (@(posedge clk) disable iff (rst)
        release_o |-> ((waiting_o == '0) && (arrived_cnt_o == '0)));

endmodule

// File: tb/barrier_sync_unit_test.sv
module barrier_sync_unit_test;

    localparam int TH = 512;
    localparam int NP = 4;
    localparam int TW = 9;
    localparam int CW = 10;

    logic             clk = 1'b0;
    logic             rst;
    logic             launch_i;
    logic [CW-1:0]    launch_size_i;
    logic [NP-1:0]    arr_valid_i;
    logic [NP*TW-1:0] arr_tid_i;
    logic             release_o;
    logic [TH-1:0]    waiting_o;
    logic [CW-1:0]    arrived_cnt_o;
    logic             active_o;
    logic             size_err_o;
    logic             arr_err_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    barrier_sync_unit uut (
        .clk           (clk),
        .rst           (rst),
        .launch_i      (launch_i),
        .launch_size_i (launch_size_i),
        .arr_valid_i   (arr_valid_i),
        .arr_tid_i     (arr_tid_i),
        .release_o     (release_o),
        .waiting_o     (waiting_o),
        .arrived_cnt_o (arrived_cnt_o),
        .active_o      (active_o),
        .size_err_o    (size_err_o),
        .arr_err_o     (arr_err_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // drive one cycle, sample just after the edge
    task automatic step(input logic l, input int sz, input logic [NP-1:0] v,
                        input int t0, input int t1, input int t2, input int t3);
        @(negedge clk);
        launch_i      = l;
        launch_size_i = CW'(sz);
        arr_valid_i   = v;
        arr_tid_i     = {TW'(t3), TW'(t2), TW'(t1), TW'(t0)};
        @(posedge clk);
        #1;
        launch_i    = 1'b0;
        arr_valid_i = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        launch_i = 1'b0; launch_size_i = '0; arr_valid_i = '0; arr_tid_i = '0;
        @(posedge clk); #1;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1", "waiting", $countones(waiting_o), 0);
        chk("R1", "count", int'(arrived_cnt_o), 0);
        chk("R1", "release", int'(release_o), 0);
        chk("R1", "active", int'(active_o), 0);
        chk("R1", "errors", int'({size_err_o, arr_err_o}), 0);
    endtask

    task automatic t_launch();
        do_reset();
        step(1, 3, 4'b0000, 0, 0, 0, 0);
        chk("R2", "active", int'(active_o), 1);
        chk("R2", "count", int'(arrived_cnt_o), 0);
        chk("R2", "size_err", int'(size_err_o), 0);
    endtask

    task automatic t_bad_launch();
        do_reset();
        step(1, 0, 4'b0000, 0, 0, 0, 0);
        chk("R3", "size0 err", int'(size_err_o), 1);
        chk("R3", "size0 active", int'(active_o), 0);
        do_reset();
        step(1, 4, 4'b0000, 0, 0, 0, 0);
        step(1, 600, 4'b0000, 0, 0, 0, 0);
        chk("R3", "oversize err", int'(size_err_o), 1);
        chk("R3", "oversize active", int'(active_o), 0);
        step(1, 4, 4'b0000, 0, 0, 0, 0);
        chk("R3", "sticky err", int'(size_err_o), 1);
        chk("R3", "relaunch active", int'(active_o), 1);
    endtask

    task automatic t_single_and_repeat();
        do_reset();
        step(1, 3, 4'b0000, 0, 0, 0, 0);
        step(0, 0, 4'b0001, 1, 0, 0, 0);
        chk("R4", "waiting[1]", int'(waiting_o[1]), 1);
        chk("R4", "count", int'(arrived_cnt_o), 1);
        chk("R4", "release", int'(release_o), 0);
        chk("R4", "arr_err", int'(arr_err_o), 0);
        step(0, 0, 4'b0001, 1, 0, 0, 0);
        chk("R8", "repeat count", int'(arrived_cnt_o), 1);
        chk("R8", "repeat err", int'(arr_err_o), 1);
    endtask

    task automatic t_multi_release();
        do_reset();
        step(1, 8, 4'b0000, 0, 0, 0, 0);
        step(0, 0, 4'b1111, 0, 1, 2, 3);
        chk("R5", "count", int'(arrived_cnt_o), 4);
        chk("R5", "waiting low", int'(waiting_o[3:0]), 15);
        chk("R11", "flags vs count", $countones(waiting_o), 4);
        step(0, 0, 4'b0111, 4, 5, 6, 0);
        chk("R11", "no early release", int'(release_o), 0);
        chk("R11", "count 7", int'(arrived_cnt_o), 7);
        step(0, 0, 4'b0001, 7, 0, 0, 0);
        chk("R6", "release", int'(release_o), 1);
        chk("R6", "count", int'(arrived_cnt_o), 0);
        chk("R6", "waiting", $countones(waiting_o), 0);
        step(0, 0, 4'b0000, 0, 0, 0, 0);
        chk("R6", "one pulse", int'(release_o), 0);
    endtask

    task automatic t_back_to_back();
        do_reset();
        step(1, 2, 4'b0000, 0, 0, 0, 0);
        step(0, 0, 4'b0011, 0, 1, 0, 0);
        chk("R7", "release", int'(release_o), 1);
        step(0, 0, 4'b0001, 0, 0, 0, 0);
        chk("R7", "next count", int'(arrived_cnt_o), 1);
        chk("R7", "next waiting[0]", int'(waiting_o[0]), 1);
        chk("R7", "release drop", int'(release_o), 0);
    endtask

    task automatic t_same_cycle_dup();
        do_reset();
        step(1, 4, 4'b0000, 0, 0, 0, 0);
        step(0, 0, 4'b0011, 2, 2, 0, 0);
        chk("R8", "dup count", int'(arrived_cnt_o), 1);
        chk("R8", "dup err", int'(arr_err_o), 1);
    endtask

    task automatic t_range();
        do_reset();
        step(1, 4, 4'b0000, 0, 0, 0, 0);
        step(0, 0, 4'b0001, 7, 0, 0, 0);
        chk("R9", "range count", int'(arrived_cnt_o), 0);
        chk("R9", "range waiting[7]", int'(waiting_o[7]), 0);
        chk("R9", "range err", int'(arr_err_o), 1);
        do_reset();
        step(0, 0, 4'b0001, 0, 0, 0, 0);
        chk("R9", "idle count", int'(arrived_cnt_o), 0);
        chk("R9", "idle waiting[0]", int'(waiting_o[0]), 0);
        chk("R9", "idle err", int'(arr_err_o), 1);
    endtask

    task automatic t_launch_ignore();
        do_reset();
        step(1, 4, 4'b0000, 0, 0, 0, 0);
        step(0, 0, 4'b0001, 0, 0, 0, 0);
        chk("R10", "pre count", int'(arrived_cnt_o), 1);
        step(1, 4, 4'b0001, 1, 0, 0, 0);
        chk("R10", "count", int'(arrived_cnt_o), 0);
        chk("R10", "waiting", $countones(waiting_o), 0);
        chk("R10", "no err", int'(arr_err_o), 0);
    endtask

    task automatic t_full_block();
        do_reset();
        step(1, 512, 4'b0000, 0, 0, 0, 0);
        for (int c = 0; c < 128; c++) begin
            step(0, 0, 4'b1111, 4*c, 4*c+1, 4*c+2, 4*c+3);
            if (c == 126) begin
                chk("R5", "full count 508", int'(arrived_cnt_o), 508);
                chk("R11", "full no release", int'(release_o), 0);
                chk("R11", "full flags", $countones(waiting_o), 508);
            end
        end
        chk("R6", "full release", int'(release_o), 1);
        chk("R6", "full waiting", $countones(waiting_o), 0);
        chk("R6", "full count", int'(arrived_cnt_o), 0);
    endtask

    initial begin
        rst = 1'b1;
        launch_i = 1'b0; launch_size_i = '0; arr_valid_i = '0; arr_tid_i = '0;
        t_reset();
        t_launch();
        t_bad_launch();
        t_single_and_repeat();
        t_multi_release();
        t_back_to_back();
        t_same_cycle_dup();
        t_range();
        t_launch_ignore();
        t_full_block();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule